// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block runs the addressing part of an I2C master transaction. Software loads two 8-bit address registers. A launch pulse then makes the block hand one or more address bytes to a byte transmitter, one at a time, over a valid/ready handshake. After each byte is accepted, the block waits for the acknowledge result before it issues anything else.

The block reads the top five bits of the first register to choose the addressing mode. If those bits are 11110, the slave is addressed with 10 bits and two bytes are sent. Any other value selects a 7-bit address and a single byte. For a 10-bit read, the block requests a repeated start after the second byte and then sends the header byte again with its direction bit set. A missing acknowledge on any address byte ends the phase, sets a sticky NACK flag and requests a stop condition.

Top module: `i2c_addr_seq`

## Requirements
- R1: After reset, both address registers read 0x0000. A write stores the 8-bit value in the low byte, and bits 15:8 of each readback are always zero.
- R2: When bits 7:3 of the first register are not 11110 (7-bit mode), exactly one byte is sent, equal to the first register (bits 7:1 address, bit 0 direction: 0 write, 1 read). The want_read input has no effect in this mode.
- R3: When bits 7:3 of the first register equal 11110 (10-bit mode), the first byte sent is the first register with bit 0 forced to 0. The second byte sent is the second register.
- R4: In 10-bit mode with want_read high, the second acknowledge is followed by a one-cycle rstart_req. The block then sends the first register with bit 0 set to 1.
- R5: A byte on tx_byte stays stable with tx_valid high until tx_ready is seen. After each accepted byte, tx_valid stays low until an acknowledge result arrives.
- R6: An acknowledge result with ack_ok low on any address byte ends the phase: stop_req pulses for one cycle, nack_flag rises and busy falls. nack_flag clears at the next accepted go.
- R7: When the final address byte is acknowledged, done pulses for one cycle and busy falls. done and stop_req are never high together.
- R8: go is ignored while busy. Register writes made during a phase do not change the bytes of that phase.
- R9: Out of reset the block is idle: tx_valid, busy, rstart_req, stop_req, done and nack_flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en0 | input | 1 | Write strobe for the first address register |
| reg_wr_en1 | input | 1 | Write strobe for the second address register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata0 | output | 16 | First address register readback |
| reg_rdata1 | output | 16 | Second address register readback |
| go | input | 1 | Launch pulse for an address phase |
| want_read | input | 1 | Read direction request, used only in 10-bit mode |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_byte | output | 8 | Address byte |
| ack_valid | input | 1 | Acknowledge result present |
| ack_ok | input | 1 | 1 = slave acknowledged, 0 = no acknowledge |
| rstart_req | output | 1 | Repeated start request pulse |
| stop_req | output | 1 | Stop condition request pulse |
| done | output | 1 | Address phase completed successfully |
| busy | output | 1 | Address phase in progress |
| nack_flag | output | 1 | Sticky no-acknowledge indicator |

## Verification
Some properties are checked on every cycle by assertions. A held byte stays stable while it waits for ready. No byte is offered between acceptance and the acknowledge. A rejected acknowledge is followed by stop and the flag. A repeated start leads straight into a read header. Done and stop never occur together. Other behaviour only shows in the bench's scenarios: the full order and content of bytes for each mode, the prefix decision on values close to 11110, the abort point inside a 10-bit read, and the effect of register writes or launches during a phase. The bench checks these against a behavioural expected-event queue.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] TEN_BIT_MARK = 5'b11110;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_RSTART} seq_state_t;
  typedef enum logic [1:0] {STEP_HEAD, STEP_LOW, STEP_RDHEAD} seq_step_t;

  function automatic logic ten_bit_hit(input logic [BYTE_W-1:0] a0);
    return a0[BYTE_W-1 -: 5] == TEN_BIT_MARK;
  endfunction

  function automatic logic [BYTE_W-1:0] step_byte(input seq_step_t st,
                                                 input logic ten,
                                                 input logic [BYTE_W-1:0] a0,
                                                 input logic [BYTE_W-1:0] a1);
    logic [BYTE_W-1:0] b;
    case (st)
      STEP_LOW:    b = a1;
      STEP_RDHEAD: b = {a0[BYTE_W-1:1], 1'b1};
      default:     b = ten ? {a0[BYTE_W-1:1], 1'b0} : a0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/i2c_addr_regs.sv
module i2c_addr_regs #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en0,
  input  logic              wr_en1,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] a0,
  output logic [BYTE_W-1:0] a1,
  output logic [WORD_W-1:0] rdata0,
  output logic [WORD_W-1:0] rdata1
);
  localparam int PAD_W = WORD_W - BYTE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a0 <= '0;
      a1 <= '0;
    end else begin
      if (wr_en0) a0 <= wdata;
      if (wr_en1) a1 <= wdata;
    end
  end

  assign rdata0 = {{PAD_W{1'b0}}, a0};
  assign rdata1 = {{PAD_W{1'b0}}, a1};

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata0[WORD_W-1:BYTE_W] == '0) && (rdata1[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/i2c_addr_byte_mux.sv
module i2c_addr_byte_mux
  import i2c_addr_pkg::*;
(
  input  seq_step_t         step,
  input  logic              ten,
  input  logic [BYTE_W-1:0] a0,
  input  logic [BYTE_W-1:0] a1,
  output logic [BYTE_W-1:0] byte_out
);
  assign byte_out = step_byte(step, ten, a0, a1);
endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              want_read,
  input  logic [BYTE_W-1:0] reg_a0,
  input  logic [BYTE_W-1:0] reg_a1,
  input  logic              tx_ready,
  input  logic              ack_valid,
  input  logic              ack_ok,
  output logic              tx_valid,
  output seq_step_t         step,
  output logic              ten,
  output logic [BYTE_W-1:0] a0_lat,
  output logic [BYTE_W-1:0] a1_lat,
  output logic              rstart_req,
  output logic              stop_req,
  output logic              done,
  output logic              busy,
  output logic              nack_flag
);
  seq_state_t state_q, state_d;
  seq_step_t  step_q, step_d;
  logic       rd_q;

  // named internal events
  logic evt_launch, evt_accept, evt_ack_good, evt_ack_bad, evt_last;
  assign evt_launch   = (state_q == ST_IDLE) && go;
  assign evt_accept   = (state_q == ST_SEND) && tx_ready;
  assign evt_ack_good = (state_q == ST_WAIT) && ack_valid && ack_ok;
  assign evt_ack_bad  = (state_q == ST_WAIT) && ack_valid && !ack_ok;
  assign evt_last     = !ten || (step_q == STEP_RDHEAD) ||
                        ((step_q == STEP_LOW) && !rd_q);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      ST_IDLE: if (evt_launch) begin
        state_d = ST_SEND;
        step_d  = STEP_HEAD;
      end
      ST_SEND: if (evt_accept) state_d = ST_WAIT;
      ST_WAIT: begin
        if (evt_ack_bad) state_d = ST_IDLE;
        else if (evt_ack_good) begin
          if (evt_last) state_d = ST_IDLE;
          else if (step_q == STEP_HEAD) begin
            state_d = ST_SEND;
            step_d  = STEP_LOW;
          end else state_d = ST_RSTART;
        end
      end
      ST_RSTART: begin
        state_d = ST_SEND;
        step_d  = STEP_RDHEAD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      step_q    <= STEP_HEAD;
      rd_q      <= 1'b0;
      ten       <= 1'b0;
      a0_lat    <= '0;
      a1_lat    <= '0;
      done      <= 1'b0;
      stop_req  <= 1'b0;
      nack_flag <= 1'b0;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      done     <= evt_ack_good && evt_last;
      stop_req <= evt_ack_bad;
      if (evt_launch) begin
        a0_lat    <= reg_a0;
        a1_lat    <= reg_a1;
        ten       <= ten_bit_hit(reg_a0);
        rd_q      <= want_read;
        nack_flag <= 1'b0;
      end else if (evt_ack_bad) begin
        nack_flag <= 1'b1;
      end
    end
  end

  assign tx_valid   = (state_q == ST_SEND);
  assign rstart_req = (state_q == ST_RSTART);
  assign busy       = (state_q != ST_IDLE);
  assign step       = step_q;

  a_r6_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ack_bad |=> stop_req && nack_flag && !busy);
  a_r5_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> !tx_valid);
  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && stop_req));
  a_r8_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go && !ack_valid && !tx_ready) |=> $stable(a0_lat) && $stable(a1_lat));
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_addr_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en0,
  input  logic              reg_wr_en1,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata0,
  output logic [WORD_W-1:0] reg_rdata1,
  input  logic              go,
  input  logic              want_read,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              ack_valid,
  input  logic              ack_ok,
  output logic              rstart_req,
  output logic              stop_req,
  output logic              done,
  output logic              busy,
  output logic              nack_flag
);
  logic [BYTE_W-1:0] reg_a0, reg_a1, a0_lat, a1_lat;
  seq_step_t step;
  logic      ten;

  i2c_addr_regs #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en0(reg_wr_en0), .wr_en1(reg_wr_en1),
    .wdata(reg_wdata), .a0(reg_a0), .a1(reg_a1),
    .rdata0(reg_rdata0), .rdata1(reg_rdata1));

  i2c_addr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .want_read(want_read),
    .reg_a0(reg_a0), .reg_a1(reg_a1), .tx_ready(tx_ready),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .tx_valid(tx_valid),
    .step(step), .ten(ten), .a0_lat(a0_lat), .a1_lat(a1_lat),
    .rstart_req(rstart_req), .stop_req(stop_req), .done(done),
    .busy(busy), .nack_flag(nack_flag));

  i2c_addr_byte_mux u_mux (
    .step(step), .ten(ten), .a0(a0_lat), .a1(a1_lat), .byte_out(tx_byte));

  a_r5_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_byte));
  a_r4_rstart_read_head: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_req |=> tx_valid && tx_byte[0]);
  a_r9_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);
endmodule

// File: tb/i2c_addr_seq_tb.sv
module i2c_addr_seq_tb;
  logic clk = 0, rst_n = 0;
  logic wr0 = 0, wr1 = 0, go = 0, want_read = 0;
  logic [7:0] wdata = 0;
  logic tx_ready = 0, ack_valid = 0, ack_ok = 0;
  logic [15:0] rd0, rd1;
  logic tx_valid, rstart_req, stop_req, done, busy, nack_flag;
  logic [7:0] tx_byte;

  int checks = 0, fails = 0, cycles = 0;
  int log_q[$];
  int exp_q[$];
  int byte_idx = 0, byte_base = 0, nack_at = -1, stall = 0, ack_dly = 1;

  always #4 clk = ~clk;

  i2c_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en0(wr0), .reg_wr_en1(wr1),
    .reg_wdata(wdata), .reg_rdata0(rd0), .reg_rdata1(rd1), .go(go),
    .want_read(want_read), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_byte(tx_byte), .ack_valid(ack_valid), .ack_ok(ack_ok),
    .rstart_req(rstart_req), .stop_req(stop_req), .done(done),
    .busy(busy), .nack_flag(nack_flag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // event monitor: bytes 0..255, 256 = repeated start, 257 = stop, 258 = done
  always @(posedge clk) if (rst_n) begin
    if (tx_valid && tx_ready) log_q.push_back(int'(tx_byte));
    if (rstart_req) log_q.push_back(256);
    if (stop_req)   log_q.push_back(257);
    if (done)       log_q.push_back(258);
  end

  // every-cycle invariants (R5, R7, R9)
  bit prev_hold = 0;
  logic [7:0] prev_byte = 0;
  always @(negedge clk) if (rst_n) begin
    if (tx_valid && !busy) chk(0, "R9 valid-without-busy", 1, 0);
    if (stop_req && done)  chk(0, "R7 done-with-stop", 1, 0);
    if (prev_hold && !(tx_valid && tx_byte == prev_byte))
      chk(0, "R5 byte-hold", int'(tx_byte), int'(prev_byte));
    prev_hold = tx_valid && !tx_ready;
    prev_byte = tx_byte;
  end

  // transmitter responder
  always begin
    @(negedge clk);
    if (tx_valid) begin
      repeat (stall) @(negedge clk);
      tx_ready = 1;
      @(negedge clk);
      tx_ready = 0;
      repeat (ack_dly) begin
        @(negedge clk);
        if (tx_valid) chk(0, "R5 byte before ack", 1, 0);
      end
      ack_valid = 1;
      ack_ok = ((byte_idx - byte_base) != nack_at);
      @(negedge clk);
      ack_valid = 0;
      ack_ok = 0;
      byte_idx++;
    end
  end

  // behavioural model of the expected event stream
  task automatic build_exp(input int a0, input int a1, input bit rd, input int nk);
    int seq[$];
    int k = 0;
    exp_q.delete();
    if ((a0 >> 3) == 'h1E) begin
      seq.push_back(a0 & 'hFE);
      seq.push_back(a1);
      if (rd) begin seq.push_back(256); seq.push_back(a0 | 1); end
    end else seq.push_back(a0);
    foreach (seq[i]) begin
      exp_q.push_back(seq[i]);
      if (seq[i] < 256) begin
        if (k == nk) begin exp_q.push_back(257); return; end
        k++;
      end
    end
    exp_q.push_back(258);
  endtask

  task automatic wr_regs(input int a0, input int a1);
    @(negedge clk); wdata = a0[7:0]; wr0 = 1;
    @(negedge clk); wr0 = 0; wdata = a1[7:0]; wr1 = 1;
    @(negedge clk); wr1 = 0;
  endtask

  task automatic run(input string req, input int a0, input int a1, input bit rd,
                     input int nk, input bit meddle);
    int base;
    wr_regs(a0, a1);
    build_exp(a0, a1, rd, nk);
    nack_at = nk;
    byte_base = byte_idx;
    base = log_q.size();
    @(negedge clk); want_read = rd; go = 1;
    @(negedge clk); go = 0;
    if (meddle) begin
      // R8: second go and register writes mid-phase must not matter
      go = 1; wdata = 8'h12; wr0 = 1; wr1 = 1;
      @(negedge clk); go = 0; wr0 = 0; wr1 = 0;
    end
    for (int t = 0; t < 500 && busy; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(log_q.size() - base == exp_q.size(), {req, " event count"},
        log_q.size() - base, exp_q.size());
    foreach (exp_q[i])
      if (base + i < log_q.size())
        chk(log_q[base + i] == exp_q[i], {req, " event"}, log_q[base + i], exp_q[i]);
    chk(nack_flag == (nk >= 0 && nk < 4 && exp_q[exp_q.size()-1] == 257),
        {req, " nack_flag"}, int'(nack_flag), int'(exp_q[exp_q.size()-1] == 257));
    chk(!busy, {req, " idle after"}, int'(busy), 0);
    if (meddle) begin
      chk(rd0 == 16'h0012, "R8 reg write landed", int'(rd0), 'h12);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state, R1 reset values
    chk(!tx_valid && !busy && !rstart_req && !stop_req && !done && !nack_flag,
        "R9 reset outputs", {tx_valid, busy, rstart_req, stop_req, done, nack_flag}, 0);
    chk(rd0 == 0 && rd1 == 0, "R1 reset regs", int'({rd0, rd1}), 0);
    wr_regs('hCD, 'hB7);
    chk(rd0 == 16'h00CD, "R1 readback0", int'(rd0), 'hCD);
    chk(rd1 == 16'h00B7, "R1 readback1", int'(rd1), 'hB7);

    run("R2 7-bit write", 'hA4, 'h55, 0, -1, 0);
    run("R2 7-bit read", 'hA5, 'h55, 0, -1, 0);
    run("R2 want_read ignored", 'hA5, 'h55, 1, -1, 0);
    run("R2 near prefix 11111", 'hF8, 'h33, 1, -1, 0);
    run("R2 near prefix 01110", 'h74, 'h33, 0, -1, 0);
    run("R3 10-bit write", 'hF6, 'h3C, 0, -1, 0);
    run("R3 10-bit bit0 forced", 'hF1, 'h81, 0, -1, 0);
    run("R4 10-bit read", 'hF6, 'h3C, 1, -1, 0);
    run("R7 10-bit read done", 'hF0, 'hFF, 1, -1, 0);
    run("R6 nack 7-bit", 'hA4, 'h00, 0, 0, 0);
    run("R6 nack clears on go", 'hA4, 'h00, 0, -1, 0);
    run("R6 nack second byte", 'hF6, 'h3C, 0, 1, 0);
    run("R6 nack read header", 'hF6, 'h3C, 1, 2, 0);
    stall = 3; ack_dly = 4;
    run("R5 stalled 10-bit read", 'hF2, 'h5A, 1, -1, 0);
    run("R8 busy go and writes", 'hF4, 'h99, 1, -1, 1);
    stall = 0; ack_dly = 1;
    run("R8 after meddle 7-bit", 'h20, 'h21, 0, -1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule